// File: doc/BRIEF.md
# USB FIFO DMA Channel Engine

This block is one DMA channel that moves data between a fixed peripheral FIFO port and memory in bursts of 32 bytes. Software programs a memory address, a count of 32-byte units, a byte mask for the final burst and a control word through a simple register port. Once the channel is enabled, the engine runs one burst at a time. Each burst is a request on the FIFO port plus a request on the memory port, and the address register of the memory side steps forward after every burst. Software can therefore work out the remaining bytes from that register while the transfer runs.

The transfer ends when the count reaches zero. It also ends when software answers a zero-length-packet indication with a forced end. A global operation register gates the whole engine, and a soft-reset register clears the channel. One level interrupt reports the end, stop and null-packet conditions.

Both request ports are valid/ready. A request is presented with valid high, and its address, strobes and write flag stay fixed until ready is seen high on a rising edge. The engine never drives the two ports in the same cycle, so a stalled port stalls the whole channel. Register access is a single-cycle write strobe with combinational read data.

Top module: `dmac_fifo_channel`

## Requirements
- R1: After reset every register reads 0. The register map for channel index 0 is: source address 0x20, destination address 0x24, unit count 0x28, control 0x34, final-burst mask 0x38, global operation 0x60, soft reset 0x08. The unit count keeps only its low 24 bits, so writing 0xFFFFFFFF reads back 0x00FFFFFF.
- R2: With control bit 3 = 0 (device to memory), each burst first completes one FIFO read request (fifo_write = 0) and then one memory write request at the destination address. After each burst the destination register advances by 32, and the source register is unchanged.
- R3: With control bit 3 = 1 (memory to device), each burst first completes one memory read request (mem_write = 0) at the source address and then one FIFO write request (fifo_write = 1). After each burst the source register advances by 32, and the destination register is unchanged.
- R4: Each burst lowers the unit count by one. The channel runs while the enable (control bit 0) is set and the end flag (control bit 1) is clear. When the count is zero in an idle cycle, the end flag is set and no further request is issued. Enabling with a count of 0 sets the end flag without any burst.
- R5: On memory write requests, mem_strb is all ones except on the burst issued while the count is 1, where it equals the final-burst mask. Bit 31 of the strobe corresponds to byte 0 of the burst.
- R6: While the null-detect enable (control bit 16) is set and the channel is running, a fifo_zlp pulse sets the null flag (control bit 12). The burst already in flight completes, and no further burst starts while the flag is set. With bit 16 clear, fifo_zlp has no effect.
- R7: Writing the force-end bit (control bit 24) with the enable set makes the channel set the end flag at the next burst boundary, without issuing more bursts. The count keeps its remaining value.
- R8: irq is high exactly when the interrupt enable (control bit 5) is set and at least one of the end, stop or null flags is set.
- R9: The flags (bits 1, 2, 12) are cleared by writing 0 to them and kept by writing 1. Software cannot set them. When the hardware sets a flag in the same cycle as a write that clears it, the flag ends up set.
- R10: Clearing the master enable (bit 0 of 0x60) or writing 1 to the soft-reset bit (bit 0 of 0x08) stops the channel at the next burst boundary. The channel enable and all flags are cleared, and no new burst starts. The operation register reads back 1 after 1 is written, with its address-error bit (bit 1) reading 0.
- R11: A request on either port keeps valid high, with a stable address, until it is accepted. mem_valid and fifo_valid are never high together.
- R12: Writing the enable bit to 0 while the channel is running with a nonzero count sets the stop flag (control bit 2). The burst in flight completes and no further burst starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_valid | output | 1 | Memory burst request valid |
| mem_ready | input | 1 | Memory burst request accepted |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory burst address |
| mem_strb | output | 32 | Byte strobes, bit 31 = first byte |
| fifo_valid | output | 1 | FIFO burst request valid |
| fifo_ready | input | 1 | FIFO burst request accepted |
| fifo_write | output | 1 | FIFO request pushes data into the FIFO |
| fifo_zlp | input | 1 | FIFO saw a zero-length packet |
| irq | output | 1 | Level interrupt |

## Verification
Two cases can land in the same clock edge. In the first, the end flag is set by the hardware in the edge where software writes the control register with that flag cleared. The bench provokes it by counting edges from the enabling write of a one-unit transfer, so that a clearing write lands exactly on the edge where the flag is set; it then judges that the flag reads back as set. In the second, a null-packet or stop indication arrives while a burst is held mid-way by a de-asserted ready. The bench judges that only that single burst completes and that the count keeps the rest.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } burst_ph_e;

  // offsets inside a channel window
  localparam int OFS_SRC = 'h00;
  localparam int OFS_DST = 'h04;
  localparam int OFS_CNT = 'h08;
  localparam int OFS_CTL = 'h14;
  localparam int OFS_FIN = 'h18;
  // global offsets
  localparam int GLB_OPR = 'h60;
  localparam int GLB_RST = 'h08;
  localparam int WIN_BASE = 'h20;
  localparam int WIN_STEP = 'h20;

  // control bit positions
  localparam int CB_EN    = 0;
  localparam int CB_END   = 1;
  localparam int CB_STOP  = 2;
  localparam int CB_DIR   = 3;
  localparam int CB_IE    = 5;
  localparam int CB_TS    = 6;
  localparam int CB_NUL   = 12;
  localparam int CB_NULEN = 16;
  localparam int CB_FORCE = 24;

endpackage

// File: rtl/dmac_burst.sv
module dmac_burst
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STRB_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_m2d,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              last,
  input  logic [STRB_W-1:0] fin_mask,
  output logic              idle,
  output logic              done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [STRB_W-1:0] mem_strb,
  output logic              fifo_valid,
  input  logic              fifo_ready,
  output logic              fifo_write
);

  burst_ph_e         ph_q;
  logic              m2d_q;
  logic [ADDR_W-1:0] addr_q;
  logic [STRB_W-1:0] strb_q;
  logic              mem_ph, fifo_ph, hs;

  always_comb begin
    mem_ph  = (ph_q == PH_FIRST && m2d_q) || (ph_q == PH_SECOND && !m2d_q);
    fifo_ph = (ph_q == PH_FIRST && !m2d_q) || (ph_q == PH_SECOND && m2d_q);
    hs      = (mem_ph && mem_ready) || (fifo_ph && fifo_ready);
    idle    = (ph_q == PH_IDLE);
    done    = (ph_q == PH_SECOND) && hs;
  end

  assign mem_valid  = mem_ph;
  assign mem_write  = mem_ph && !m2d_q;
  assign mem_addr   = mem_ph ? addr_q : '0;
  assign mem_strb   = !mem_ph ? '0 : (m2d_q ? '1 : strb_q);
  assign fifo_valid = fifo_ph;
  assign fifo_write = fifo_ph && m2d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      m2d_q  <= 1'b0;
      addr_q <= '0;
      strb_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start) begin
          ph_q   <= PH_FIRST;
          m2d_q  <= dir_m2d;
          addr_q <= dir_m2d ? src_addr : dst_addr;
          strb_q <= last ? fin_mask : '1;
        end
        PH_FIRST:  if (hs) ph_q <= PH_SECOND;
        PH_SECOND: if (hs) ph_q <= PH_IDLE;
        default:   ph_q <= PH_IDLE;
      endcase
    end
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_strb)))
    else $error("memory request dropped before acceptance");

  // R11
  fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid && !fifo_ready) |=> (fifo_valid && $stable(fifo_write)))
    else $error("fifo request dropped before acceptance");

endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int CH_INDEX    = 0,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 24,
  parameter int BURST_BYTES = 32,
  parameter int REG_AW      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [REG_AW-1:0]      reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic                   fifo_zlp,
  input  logic                   fsm_idle,
  input  logic                   burst_done,
  output logic                   start,
  output logic                   dir_m2d,
  output logic [ADDR_W-1:0]      src_addr,
  output logic [ADDR_W-1:0]      dst_addr,
  output logic                   last,
  output logic [BURST_BYTES-1:0] fin_mask,
  output logic                   irq
);

  localparam int CH_BASE = WIN_BASE + WIN_STEP * CH_INDEX;
  localparam logic [REG_AW-1:0] A_SRC = REG_AW'(CH_BASE + OFS_SRC);
  localparam logic [REG_AW-1:0] A_DST = REG_AW'(CH_BASE + OFS_DST);
  localparam logic [REG_AW-1:0] A_CNT = REG_AW'(CH_BASE + OFS_CNT);
  localparam logic [REG_AW-1:0] A_CTL = REG_AW'(CH_BASE + OFS_CTL);
  localparam logic [REG_AW-1:0] A_FIN = REG_AW'(CH_BASE + OFS_FIN);
  localparam logic [REG_AW-1:0] A_OPR = REG_AW'(GLB_OPR);
  localparam logic [REG_AW-1:0] A_RST = REG_AW'(GLB_RST);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(BURST_BYTES);

  logic [ADDR_W-1:0]      src_q, dst_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [BURST_BYTES-1:0] fin_q;
  logic                   de_q, te_q, sp_q, nul_q, fte_q;
  logic                   ie_q, nule_q, m2d_q;
  logic [1:0]             ts_q;
  logic                   dme_q, swr_q;

  logic wr_src, wr_dst, wr_cnt, wr_ctl, wr_fin, wr_opr, wr_rst;
  logic halt, halt_clr, busy, cnt_zero;
  logic te_set, sp_set, nul_set;

  always_comb begin
    wr_src   = reg_wr && reg_addr == A_SRC;
    wr_dst   = reg_wr && reg_addr == A_DST;
    wr_cnt   = reg_wr && reg_addr == A_CNT;
    wr_ctl   = reg_wr && reg_addr == A_CTL;
    wr_fin   = reg_wr && reg_addr == A_FIN;
    wr_opr   = reg_wr && reg_addr == A_OPR;
    wr_rst   = reg_wr && reg_addr == A_RST;
    halt     = !dme_q || swr_q;
    halt_clr = halt && fsm_idle;
    busy     = de_q && !te_q;
    cnt_zero = (cnt_q == '0);
    te_set   = fsm_idle && busy && !halt && (cnt_zero || fte_q);
    sp_set   = wr_ctl && !reg_wdata[CB_EN] && busy && !cnt_zero;
    nul_set  = nule_q && busy && !halt && fifo_zlp;
    start    = fsm_idle && busy && !halt && !sp_q && !nul_q && !fte_q && !cnt_zero;
  end

  // control and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q <= 1'b0; te_q <= 1'b0; sp_q <= 1'b0; nul_q <= 1'b0; fte_q <= 1'b0;
      ie_q <= 1'b0; nule_q <= 1'b0; m2d_q <= 1'b0; ts_q <= 2'b00;
    end else if (halt_clr) begin
      de_q <= 1'b0; te_q <= 1'b0; sp_q <= 1'b0; nul_q <= 1'b0; fte_q <= 1'b0;
      if (wr_ctl) begin
        ie_q   <= reg_wdata[CB_IE];
        nule_q <= reg_wdata[CB_NULEN];
        m2d_q  <= reg_wdata[CB_DIR];
        ts_q   <= reg_wdata[CB_TS+:2];
      end
    end else if (wr_ctl) begin
      de_q   <= reg_wdata[CB_EN];
      ie_q   <= reg_wdata[CB_IE];
      nule_q <= reg_wdata[CB_NULEN];
      m2d_q  <= reg_wdata[CB_DIR];
      ts_q   <= reg_wdata[CB_TS+:2];
      te_q   <= te_set  || (te_q  && reg_wdata[CB_END]);
      sp_q   <= sp_set  || (sp_q  && reg_wdata[CB_STOP]);
      nul_q  <= nul_set || (nul_q && reg_wdata[CB_NUL]);
      fte_q  <= !te_set && reg_wdata[CB_EN] && (fte_q || reg_wdata[CB_FORCE]);
    end else begin
      te_q  <= te_q  || te_set;
      nul_q <= nul_q || nul_set;
      fte_q <= fte_q && !te_set;
    end
  end

  // addresses, count, mask, global
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0; fin_q <= '0;
      dme_q <= 1'b0; swr_q <= 1'b0;
    end else begin
      if (wr_src)                     src_q <= ADDR_W'(reg_wdata);
      else if (burst_done && m2d_q)   src_q <= src_q + STEP;
      if (wr_dst)                     dst_q <= ADDR_W'(reg_wdata);
      else if (burst_done && !m2d_q)  dst_q <= dst_q + STEP;
      if (wr_cnt)                     cnt_q <= reg_wdata[CNT_W-1:0];
      else if (burst_done)            cnt_q <= cnt_q - 1'b1;
      if (wr_fin)                     fin_q <= reg_wdata[BURST_BYTES-1:0];
      if (wr_opr)                     dme_q <= reg_wdata[0];
      if (wr_rst)                     swr_q <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SRC: reg_rdata = 32'(src_q);
      A_DST: reg_rdata = 32'(dst_q);
      A_CNT: reg_rdata = 32'(cnt_q);
      A_FIN: reg_rdata = 32'(fin_q);
      A_OPR: reg_rdata = {30'b0, 1'b0, dme_q};
      A_RST: reg_rdata = {31'b0, swr_q};
      A_CTL: begin
        reg_rdata[CB_EN]      = de_q;
        reg_rdata[CB_END]     = te_q;
        reg_rdata[CB_STOP]    = sp_q;
        reg_rdata[CB_DIR]     = m2d_q;
        reg_rdata[CB_IE]      = ie_q;
        reg_rdata[CB_TS+:2]   = ts_q;
        reg_rdata[CB_NUL]     = nul_q;
        reg_rdata[CB_NULEN]   = nule_q;
        reg_rdata[CB_FORCE]   = fte_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign dir_m2d  = m2d_q;
  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign last     = (cnt_q == CNT_W'(1));
  assign fin_mask = fin_q;
  assign irq      = ie_q && (te_q || sp_q || nul_q);

  // R4
  end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te_q) |-> ($past(cnt_q) == '0 || $past(fte_q)))
    else $error("end flag set with units left and no forced end");

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && !wr_cnt) |=> (cnt_q == $past(cnt_q) - 1'b1))
    else $error("count did not step on burst completion");

  // R12
  stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sp_q) |-> $past(de_q))
    else $error("stop flag set on an idle channel");

endmodule

// File: rtl/dmac_fifo_channel.sv
module dmac_fifo_channel
  import dmac_pkg::*;
#(
  parameter int CH_INDEX    = 0,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 24,
  parameter int BURST_BYTES = 32,
  parameter int REG_AW      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [REG_AW-1:0]      reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic                   mem_valid,
  input  logic                   mem_ready,
  output logic                   mem_write,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [BURST_BYTES-1:0] mem_strb,
  output logic                   fifo_valid,
  input  logic                   fifo_ready,
  output logic                   fifo_write,
  input  logic                   fifo_zlp,
  output logic                   irq
);

  logic                   start, dir_m2d, last, fsm_idle, burst_done;
  logic [ADDR_W-1:0]      src_addr, dst_addr;
  logic [BURST_BYTES-1:0] fin_mask;

  dmac_regs #(
    .CH_INDEX(CH_INDEX), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .BURST_BYTES(BURST_BYTES), .REG_AW(REG_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fifo_zlp(fifo_zlp), .fsm_idle(fsm_idle), .burst_done(burst_done),
    .start(start), .dir_m2d(dir_m2d), .src_addr(src_addr), .dst_addr(dst_addr),
    .last(last), .fin_mask(fin_mask), .irq(irq)
  );

  dmac_burst #(.ADDR_W(ADDR_W), .STRB_W(BURST_BYTES)) u_burst (
    .clk(clk), .rst_n(rst_n),
    .start(start), .dir_m2d(dir_m2d), .src_addr(src_addr), .dst_addr(dst_addr),
    .last(last), .fin_mask(fin_mask), .idle(fsm_idle), .done(burst_done),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_strb(mem_strb),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_write(fifo_write)
  );

endmodule

// File: tb/sim_dmac_fifo_channel.sv
module sim_dmac_fifo_channel;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_SRC = 8'h20, A_DST = 8'h24, A_CNT = 8'h28,
                         A_CTL = 8'h34, A_FIN = 8'h38, A_OPR = 8'h60, A_RST = 8'h08;
  localparam logic [31:0] C_EN = 32'h1, C_END = 32'h2, C_STOP = 32'h4, C_DIR = 32'h8,
                          C_IE = 32'h20, C_TS32 = 32'h80, C_NUL = 32'h1000,
                          C_NULEN = 32'h1_0000, C_FORCE = 32'h100_0000;
  localparam logic [31:0] FLAGMASK = C_EN | C_END | C_STOP | C_NUL;

  // {backpressure, m2d, count[23:0], final mask[31:0], address[31:0]}
  localparam logic [89:0] VEC [5] = '{
    {1'b0, 1'b0, 24'd1, 32'hFFFF_FFFF, 32'h0000_1000},
    {1'b0, 1'b0, 24'd3, 32'hF000_0000, 32'h0000_2000},
    {1'b0, 1'b1, 24'd2, 32'hFFFF_0000, 32'h0000_3000},
    {1'b1, 1'b1, 24'd4, 32'hFFFF_FFFF, 32'h0000_4000},
    {1'b1, 1'b0, 24'd5, 32'h8000_0000, 32'h0000_5000}
  };

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, mem_ready = 1, fifo_ready = 1, fifo_zlp = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, mem_addr, mem_strb;
  logic mem_valid, mem_write, fifo_valid, fifo_write, irq;

  int n_chk = 0, n_fail = 0, rdy_mode = 0;
  int n_mem = 0, n_fifo = 0, ord_bad = 0, hold_bad = 0;
  logic [31:0] log_addr [16];
  logic [31:0] log_strb [16];
  logic        log_wr   [16];
  logic p_mv = 0, p_mr = 0, p_fv = 0, p_fr = 0, p_fw = 0;
  logic [31:0] p_ma = 0;

  dmac_fifo_channel u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_strb(mem_strb), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .fifo_write(fifo_write), .fifo_zlp(fifo_zlp), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ready pattern: 0 always ready, 1 alternating, 2 stalled
  always @(negedge clk) begin
    case (rdy_mode)
      0: begin mem_ready = 1; fifo_ready = 1; end
      1: begin mem_ready = ~mem_ready; fifo_ready = ~fifo_ready; end
      default: begin mem_ready = 0; fifo_ready = 0; end
    endcase
  end

  // monitor, sampled one time unit before each rising edge
  always @(negedge clk) begin
    #(CLK_PERIOD/2 - 1);
    if (rst_n) begin
      if (mem_valid && mem_ready) begin
        if (n_mem < 16) begin
          log_addr[n_mem] = mem_addr; log_strb[n_mem] = mem_strb; log_wr[n_mem] = mem_write;
        end
        if (mem_write ? (n_fifo != n_mem + 1) : (n_fifo != n_mem)) ord_bad++;
        n_mem++;
      end
      if (fifo_valid && fifo_ready) begin
        if (fifo_write ? (n_mem != n_fifo + 1) : (n_mem != n_fifo)) ord_bad++;
        n_fifo++;
      end
      if (p_mv && !p_mr && (!mem_valid || mem_addr != p_ma)) hold_bad++;
      if (p_fv && !p_fr && (!fifo_valid || fifo_write != p_fw)) hold_bad++;
      if (mem_valid && fifo_valid) hold_bad++;
      p_mv = mem_valid; p_mr = mem_ready; p_ma = mem_addr;
      p_fv = fifo_valid; p_fr = fifo_ready; p_fw = fifo_write;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq(input int n);
    for (int i = 0; i < n; i++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  task automatic clear_log;
    n_mem = 0; n_fifo = 0;
  endtask

  task automatic zlp_pulse;
    @(negedge clk); fifo_zlp = 1;
    @(negedge clk); fifo_zlp = 0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r, a, fin;
    logic m2d;
    int cnt, bad, n0;
    string tg;

    cyc(3); rst_n = 1; cyc(2);

    // reset state
    rd(A_SRC, r); chk(r == 0, "R1", "src reset", r, 0);
    rd(A_DST, r); chk(r == 0, "R1", "dst reset", r, 0);
    rd(A_CNT, r); chk(r == 0, "R1", "count reset", r, 0);
    rd(A_CTL, r); chk(r == 0, "R1", "control reset", r, 0);
    rd(A_FIN, r); chk(r == 0, "R1", "mask reset", r, 0);
    rd(A_OPR, r); chk(r == 0, "R1", "operation reset", r, 0);
    rd(A_RST, r); chk(r == 0, "R1", "soft reset reg", r, 0);
    chk(!irq && !mem_valid && !fifo_valid, "R1", "outputs idle", {irq, mem_valid, fifo_valid}, 0);
    wr(A_CNT, 32'hFFFF_FFFF);
    rd(A_CNT, r); chk(r == 32'h00FF_FFFF, "R1", "count width", r, 32'h00FF_FFFF);
    wr(A_CNT, 0);

    wr(A_OPR, 1);
    rd(A_OPR, r); chk(r == 1, "R10", "master enable readback", r, 1);

    // table of transfers
    for (int v = 0; v < 5; v++) begin
      m2d = VEC[v][88]; cnt = int'(VEC[v][87:64]); fin = VEC[v][63:32]; a = VEC[v][31:0];
      tg = m2d ? "R3" : "R2";
      rdy_mode = int'(VEC[v][89]);
      clear_log();
      wr(A_SRC, m2d ? a : 0);
      wr(A_DST, m2d ? 0 : a);
      wr(A_CNT, cnt);
      wr(A_FIN, fin);
      wr(A_CTL, C_EN | C_IE | C_TS32 | (m2d ? C_DIR : 0));
      wait_irq(500);
      chk(n_mem == cnt, tg, "memory bursts", n_mem, cnt);
      chk(n_fifo == cnt, tg, "fifo bursts", n_fifo, cnt);
      chk(ord_bad == 0, tg, "port order", ord_bad, 0);
      bad = 0;
      for (int k = 0; k < cnt; k++) begin
        if (log_addr[k] != a + 32 * k) bad++;
        if (log_wr[k] != !m2d) bad++;
      end
      chk(bad == 0, tg, "address and direction per burst", bad, 0);
      rd(m2d ? A_SRC : A_DST, r); chk(r == a + 32 * cnt, tg, "advanced address", r, a + 32 * cnt);
      rd(m2d ? A_DST : A_SRC, r); chk(r == 0, tg, "fixed address", r, 0);
      rd(A_CNT, r); chk(r == 0, "R4", "count exhausted", r, 0);
      rd(A_CTL, r); chk(r[1] == 1'b1, "R4", "end flag", r, 32'h2);
      chk(irq == 1'b1, "R8", "irq on end", irq, 1);
      if (!m2d) begin
        bad = 0;
        for (int k = 0; k < cnt - 1; k++) if (log_strb[k] != 32'hFFFF_FFFF) bad++;
        chk(bad == 0, "R5", "full strobes", bad, 0);
        chk(log_strb[cnt-1] == fin, "R5", "last strobes", log_strb[cnt-1], fin);
      end
      n0 = n_mem; cyc(10);
      chk(n_mem == n0, "R4", "no request after end", n_mem, n0);
      wr(A_CTL, 0);
      chk(irq == 1'b0, "R9", "zero write clears", irq, 0);
    end
    rdy_mode = 0;

    // zero count, interrupt disabled
    clear_log();
    wr(A_CNT, 0);
    wr(A_CTL, C_EN);
    cyc(5);
    rd(A_CTL, r); chk(r[1] == 1'b1, "R4", "zero count ends", r, 32'h3);
    chk(n_mem == 0, "R4", "zero count no burst", n_mem, 0);
    chk(irq == 1'b0, "R8", "irq masked", irq, 0);
    wr(A_CTL, C_EN | C_IE | C_END);
    rd(A_CTL, r); chk(r[1] == 1'b1, "R9", "one keeps flag", r, 32'h23);
    chk(irq == 1'b1, "R8", "irq unmasked", irq, 1);
    wr(A_CTL, 0);

    // null packet then forced end
    rdy_mode = 2; clear_log();
    wr(A_DST, 32'h8000); wr(A_CNT, 5); wr(A_FIN, 32'hFFFF_FFFF);
    wr(A_CTL, C_EN | C_IE | C_NULEN);
    cyc(3); zlp_pulse();
    rd(A_CTL, r); chk(r[12] == 1'b1, "R6", "null flag", r, C_NUL);
    chk(irq == 1'b1, "R8", "irq on null", irq, 1);
    rdy_mode = 0; cyc(20);
    chk(n_mem == 1, "R6", "paused after in-flight burst", n_mem, 1);
    rd(A_CNT, r); chk(r == 4, "R6", "count while paused", r, 4);
    wr(A_CTL, C_EN | C_IE | C_NULEN | C_FORCE);
    cyc(5);
    rd(A_CTL, r); chk(r[1] == 1'b1 && r[12] == 1'b0, "R7", "forced end", r & FLAGMASK, 32'h3);
    rd(A_CNT, r); chk(r == 4, "R7", "remaining count kept", r, 4);
    chk(n_mem == 1, "R7", "no burst after force", n_mem, 1);
    wr(A_CTL, 0);

    // zero-length packet ignored without detect enable
    rdy_mode = 2; clear_log();
    wr(A_DST, 32'h9000); wr(A_CNT, 2);
    wr(A_CTL, C_EN | C_IE);
    cyc(3); zlp_pulse();
    rd(A_CTL, r); chk(r[12] == 1'b0, "R6", "null ignored", r, C_EN | C_IE);
    chk(irq == 1'b0, "R6", "no irq on ignored null", irq, 0);
    rdy_mode = 0; wait_irq(100);
    chk(n_mem == 2, "R6", "transfer unaffected", n_mem, 2);
    wr(A_CTL, 0);

    // stop by clearing enable
    rdy_mode = 2; clear_log();
    wr(A_DST, 32'hA000); wr(A_CNT, 4);
    wr(A_CTL, C_EN | C_IE);
    cyc(3);
    wr(A_CTL, C_IE);
    rd(A_CTL, r); chk(r[2] == 1'b1, "R12", "stop flag", r, C_IE | C_STOP);
    chk(irq == 1'b1, "R8", "irq on stop", irq, 1);
    rdy_mode = 0; cyc(20);
    chk(n_mem == 1, "R12", "only in-flight burst", n_mem, 1);
    rd(A_CNT, r); chk(r == 3, "R12", "count after stop", r, 3);
    wr(A_CTL, 0);
    rd(A_CTL, r); chk(r == 0, "R9", "stop flag cleared", r, 0);

    // hardware end in the same edge as a clearing write
    clear_log();
    wr(A_DST, 32'hB000); wr(A_CNT, 1);
    @(negedge clk); reg_wr = 1; reg_addr = A_CTL; reg_wdata = C_EN | C_IE;
    @(negedge clk); reg_wr = 0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); reg_wr = 1; reg_addr = A_CTL; reg_wdata = C_EN | C_IE;
    @(negedge clk); reg_wr = 0;
    rd(A_CTL, r); chk(r[1] == 1'b1, "R9", "set wins over clear", r, 32'h23);
    chk(n_mem == 1, "R9", "single burst", n_mem, 1);
    wr(A_CTL, C_EN | C_IE);
    rd(A_CTL, r); chk(r[1] == 1'b0, "R9", "later clear works", r, 32'h21);
    wr(A_CTL, 0);

    // master enable cleared mid transfer
    rdy_mode = 1; clear_log();
    wr(A_DST, 32'hC000); wr(A_CNT, 8);
    wr(A_CTL, C_EN | C_IE);
    cyc(6);
    wr(A_OPR, 0);
    cyc(10);
    rd(A_CTL, r); chk((r & FLAGMASK) == 0, "R10", "halt clears channel", r & FLAGMASK, 0);
    n0 = n_mem; cyc(20);
    chk(n_mem == n0 && n0 < 8, "R10", "no burst while halted", n_mem, n0);
    rd(A_OPR, r); chk(r == 0, "R10", "operation cleared", r, 0);
    wr(A_OPR, 1);
    rd(A_OPR, r); chk(r == 1, "R10", "enable back, no address error", r, 1);
    rdy_mode = 0;

    // soft reset mid transfer
    rdy_mode = 2; clear_log();
    wr(A_DST, 32'hD000); wr(A_CNT, 3);
    wr(A_CTL, C_EN | C_IE);
    cyc(3);
    wr(A_RST, 1);
    rd(A_RST, r); chk(r == 1, "R10", "soft reset readback", r, 1);
    rdy_mode = 0; cyc(10);
    rd(A_CTL, r); chk((r & FLAGMASK) == 0, "R10", "soft reset clears channel", r & FLAGMASK, 0);
    chk(n_mem == 1, "R10", "soft reset at burst boundary", n_mem, 1);
    chk(irq == 1'b0, "R10", "no irq after soft reset", irq, 0);
    wr(A_RST, 0);

    chk(hold_bad == 0, "R11", "valid held until ready", hold_bad, 0);
    chk(ord_bad == 0, "R2", "burst port order overall", ord_bad, 0);

    summary();
    $finish;
  end
endmodule